// File: doc/BRIEF.md
# Incrementing Burst Master with Selectable Error Handling

This block is a bus master for a single-master AHB-Lite segment. It takes one command at a time and turns it into an incrementing burst. A command gives a start address, a beat count, a direction and a policy bit. The block then drives the address phase, presents write data in each data phase, and returns read data. A count of beats that completed without error and a sticky error flag report how the burst ended.

The policy bit sets what happens when a beat gets an ERROR response. In abort mode the master drops to IDLE in the second cycle of the two-cycle ERROR response and does not issue the rest of the burst. In continue mode it keeps the next SEQ beat on the bus through both error cycles. That beat is accepted when HREADY rises, and the burst runs to its end. The same choice is made again for every beat that errors. A command that follows a cancelled burst starts with a fresh NONSEQ transfer.

Write data comes from a valid/ready source. An item is taken when the master decides to present the beat's address. If no item is waiting, the master shows BUSY in the middle of a burst, or stays IDLE before the first beat. Read data leaves on a valid strobe that has no back-pressure. The consumer must take every item.

Top module: `ahbl_burst_master`

## Requirements
- R1: `cmd_ready` is high exactly when no burst is in progress. A command is taken on a cycle where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is low on the cycle after a command is taken.
- R2: The first beat of a burst is NONSEQ and each later beat is SEQ. The address of beat i is start + i·2^HSIZE. With 32-bit data, HSIZE is 2 (word), so each beat adds 4 bytes.
- R3: HTRANS uses IDLE=00, BUSY=01, NONSEQ=10, SEQ=11. HBURST is 011 (INCR4) for 4 beats, 101 (INCR8) for 8 beats, and 001 (INCR) for any other count. After reset HTRANS is IDLE.
- R4: While HREADY is low and the response is OKAY, HADDR and HTRANS hold their values.
- R5: In abort mode (`cmd_abort`=1), when a beat gets ERROR, HTRANS is IDLE in the second ERROR cycle and no later beat of that burst is issued. The next command starts with NONSEQ.
- R6: In continue mode (`cmd_abort`=0), during the second ERROR cycle the next beat is on the bus as SEQ at the incremented address. The burst then completes every beat, and each further error is handled the same way.
- R7: HTRANS never goes from IDLE to SEQ.
- R8: An item is taken from the write port (`wr_valid`&`wr_ready`) each time a write beat's address is presented, and appears on HWDATA in that beat's data phase. If no item is waiting mid-burst, HTRANS shows BUSY. In abort mode, an item taken for a cancelled beat is discarded.
- R9: `rd_valid` pulses for one cycle, carrying HRDATA, for each read beat that ends with HREADY high and an OKAY response, and at no other time.
- R10: `beats_done` counts beats that ended with HREADY high and OKAY. `err_flag` is set on any ERROR response and stays set until the next command is taken, which clears both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Master idle, command can be taken |
| cmd_addr | input | ADDR_W | Start byte address |
| cmd_beats | input | CNT_W | Number of beats |
| cmd_write | input | 1 | 1 = write burst, 0 = read burst |
| cmd_abort | input | 1 | 1 = cancel on ERROR, 0 = continue |
| haddr | output | ADDR_W | Bus address |
| htrans | output | 2 | Transfer type |
| hburst | output | 3 | Burst type |
| hsize | output | 3 | Transfer size |
| hwrite | output | 1 | Transfer direction |
| hwdata | output | DATA_W | Write data |
| hrdata | input | DATA_W | Read data |
| hready | input | 1 | Transfer done / bus ready |
| hresp | input | 1 | 1 = ERROR response |
| wr_valid | input | 1 | Write item available |
| wr_ready | output | 1 | Write item taken |
| wr_data | input | DATA_W | Write item |
| rd_valid | output | 1 | Read item strobe |
| rd_data | output | DATA_W | Read item |
| beats_done | output | CNT_W | Beats completed with OKAY |
| err_flag | output | 1 | Sticky error indication |

## Verification
The bound checker watches a set of bus rules on every cycle: the address phase holds while HREADY is low, IDLE is never followed by SEQ, each accepted beat is followed by a SEQ at the next address, the error handling follows the policy in the first error cycle, and the command port and error flag behave as stated. Other properties need a slave model and are shown only by the bench's scenarios. These are whole-burst beat counts after an abort or a chain of errors, the dropped write item after a cancel, BUSY insertion when write data is late, HBURST coding, and the read and write data values.

// File: rtl/ahbm_pkg.sv
package ahbm_pkg;

    typedef enum logic [1:0] {
        TR_IDLE = 2'b00,
        TR_BUSY = 2'b01,
        TR_NSEQ = 2'b10,
        TR_SEQ  = 2'b11
    } htrans_e;

    typedef enum logic [2:0] {
        BU_INCR  = 3'b001,
        BU_INCR4 = 3'b011,
        BU_INCR8 = 3'b101
    } hburst_e;

endpackage

// File: rtl/ahbm_burst_code.sv
module ahbm_burst_code
    import ahbm_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic [CNT_W-1:0] beats,
    output hburst_e          code
);
    always_comb begin
        if (beats == CNT_W'(4))      code = BU_INCR4;
        else if (beats == CNT_W'(8)) code = BU_INCR8;
        else                         code = BU_INCR;
    end
endmodule

// File: rtl/ahbm_addr_calc.sv
module ahbm_addr_calc #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 5,
    parameter int SZ     = 2
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [CNT_W-1:0]  idx,
    output logic [ADDR_W-1:0] addr
);
    // beat address = base + idx * 2^SZ
    assign addr = base + (ADDR_W'(idx) << SZ);
endmodule

// File: rtl/ahbl_burst_master.sv
module ahbl_burst_master
    import ahbm_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 32,
    parameter int MAX_BEATS = 16,
    parameter int CNT_W     = $clog2(MAX_BEATS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [CNT_W-1:0]  cmd_beats,
    input  logic              cmd_write,
    input  logic              cmd_abort,
    output logic [ADDR_W-1:0] haddr,
    output logic [1:0]        htrans,
    output logic [2:0]        hburst,
    output logic [2:0]        hsize,
    output logic              hwrite,
    output logic [DATA_W-1:0] hwdata,
    input  logic [DATA_W-1:0] hrdata,
    input  logic              hready,
    input  logic              hresp,
    input  logic              wr_valid,
    output logic              wr_ready,
    input  logic [DATA_W-1:0] wr_data,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [CNT_W-1:0]  beats_done,
    output logic              err_flag
);
    localparam int SZ = $clog2(DATA_W / 8);

    typedef struct packed {
        logic              busy;
        logic              cancel;
        logic              pol;
        logic              wr;
        logic              dph;
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] addr;
        htrans_e           trans;
        hburst_e           burst;
        logic [CNT_W-1:0]  beats;
        logic [CNT_W-1:0]  issued;
        logic [CNT_W-1:0]  done;
        logic              err;
        logic [DATA_W-1:0] pend;
        logic [DATA_W-1:0] wdat;
    } st_t;

    st_t s_q, s_d;

    logic              acc_w, dend_w, err1_w, wr_take_w;
    logic [CNT_W-1:0]  issued_nx_w;
    logic [ADDR_W-1:0] next_addr_w;
    hburst_e           burst_w;
    logic              pol_w, dph_w;

    ahbm_burst_code #(.CNT_W(CNT_W)) u_code (
        .beats (cmd_beats),
        .code  (burst_w)
    );

    ahbm_addr_calc #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .SZ(SZ)) u_addr (
        .base (s_q.base),
        .idx  (issued_nx_w),
        .addr (next_addr_w)
    );

    assign acc_w       = hready && (s_q.trans == TR_NSEQ || s_q.trans == TR_SEQ);
    assign dend_w      = s_q.dph && hready;
    assign err1_w      = s_q.dph && !hready && hresp;
    assign issued_nx_w = s_q.issued + CNT_W'(acc_w);

    always_comb begin
        s_d       = s_q;
        wr_take_w = 1'b0;

        // data phase retires
        if (dend_w) begin
            s_d.dph = 1'b0;
            if (!hresp) s_d.done = s_q.done + CNT_W'(1);
        end

        // address phase accepted: it becomes the data phase
        if (acc_w) begin
            s_d.dph    = 1'b1;
            s_d.issued = issued_nx_w;
            s_d.wdat   = s_q.pend;
        end

        // first ERROR cycle: the policy decision point
        if (err1_w) begin
            s_d.err = 1'b1;
            if (s_q.pol) begin
                s_d.cancel = 1'b1;
                s_d.trans  = TR_IDLE;
            end
        end

        // next address phase, only when the bus moves
        if (s_q.busy && hready) begin
            if (s_q.cancel || issued_nx_w == s_q.beats) begin
                s_d.trans = TR_IDLE;
            end else if (!s_q.wr || wr_valid) begin
                s_d.trans = (issued_nx_w == '0) ? TR_NSEQ : TR_SEQ;
                s_d.addr  = next_addr_w;
                if (s_q.wr) begin
                    wr_take_w = 1'b1;
                    s_d.pend  = wr_data;
                end
            end else begin
                s_d.trans = (issued_nx_w == '0) ? TR_IDLE : TR_BUSY;
                s_d.addr  = next_addr_w;
            end
        end

        if (s_q.busy && !s_d.dph && s_d.trans == TR_IDLE &&
            (s_d.cancel || s_d.issued == s_q.beats)) begin
            s_d.busy = 1'b0;
        end

        // command intake
        if (!s_q.busy && cmd_valid) begin
            s_d.busy   = 1'b1;
            s_d.base   = cmd_addr;
            s_d.beats  = cmd_beats;
            s_d.wr     = cmd_write;
            s_d.pol    = cmd_abort;
            s_d.burst  = burst_w;
            s_d.issued = '0;
            s_d.cancel = 1'b0;
            s_d.done   = '0;
            s_d.err    = 1'b0;
            s_d.trans  = TR_IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.trans <= TR_IDLE;
            s_q.burst <= BU_INCR;
        end else begin
            s_q <= s_d;
        end
    end

    assign cmd_ready  = !s_q.busy;
    assign haddr      = s_q.addr;
    assign htrans     = s_q.trans;
    assign hburst     = s_q.burst;
    assign hsize      = 3'(SZ);
    assign hwrite     = s_q.wr;
    assign hwdata     = s_q.wdat;
    assign wr_ready   = wr_take_w;
    assign rd_valid   = dend_w && !hresp && !s_q.wr;
    assign rd_data    = hrdata;
    assign beats_done = s_q.done;
    assign err_flag   = s_q.err;
    assign pol_w      = s_q.pol;
    assign dph_w      = s_q.dph;

endmodule

// File: rtl/ahbl_burst_master_chk.sv
module ahbl_burst_master_chk #(
    parameter int ADDR_W = 32,
    parameter int STEP   = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hready,
    input logic              hresp,
    input logic [1:0]        htrans,
    input logic [ADDR_W-1:0] haddr,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic              err_flag,
    input logic              pol,
    input logic              dph
);
    assert_addr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (hready && htrans[1]) |=> (htrans != 2'b11 || haddr == $past(haddr) + ADDR_W'(STEP)));

    assert_hold_on_wait_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!hready && !hresp && htrans[1]) |=> ($stable(haddr) && $stable(htrans)));

    assert_abort_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (dph && !hready && hresp && pol) |=> (htrans == 2'b00));

    assert_continue_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (dph && !hready && hresp && !pol) |=> ($stable(htrans) && $stable(haddr)));

    assert_no_idle_seq_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (htrans == 2'b00) |=> (htrans != 2'b11));

    assert_ready_only_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (htrans != 2'b00) |-> !cmd_ready);

    assert_err_sets_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (dph && !hready && hresp) |=> err_flag);

    assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && !(cmd_valid && cmd_ready)) |=> err_flag);
endmodule

bind ahbl_burst_master ahbl_burst_master_chk #(
    .ADDR_W (ADDR_W),
    .STEP   (DATA_W / 8)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .hready    (hready),
    .hresp     (hresp),
    .htrans    (htrans),
    .haddr     (haddr),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .err_flag  (err_flag),
    .pol       (pol_w),
    .dph       (dph_w)
);

// File: tb/ahbl_burst_master_tb_top.sv
`timescale 1ns/1ps
module ahbl_burst_master_tb_top;
    localparam int AW = 32;
    localparam int DW = 32;
    localparam int CW = 5;
    localparam logic [DW-1:0] WBASE = 32'hC0DE_0000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0, cmd_ready;
    logic [AW-1:0] cmd_addr = '0;
    logic [CW-1:0] cmd_beats = '0;
    logic          cmd_write = 1'b0, cmd_abort = 1'b0;
    logic [AW-1:0] haddr;
    logic [1:0]    htrans;
    logic [2:0]    hburst, hsize;
    logic          hwrite;
    logic [DW-1:0] hwdata, hrdata = '0;
    logic          hready = 1'b1, hresp = 1'b0;
    logic          wr_valid = 1'b1, wr_ready;
    logic [DW-1:0] wr_data = WBASE;
    logic          rd_valid;
    logic [DW-1:0] rd_data;
    logic [CW-1:0] beats_done;
    logic          err_flag;

    always #5 clk = ~clk;

    ahbl_burst_master #(.ADDR_W(AW), .DATA_W(DW), .MAX_BEATS(16)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr),
        .cmd_beats(cmd_beats), .cmd_write(cmd_write), .cmd_abort(cmd_abort),
        .haddr(haddr), .htrans(htrans), .hburst(hburst), .hsize(hsize),
        .hwrite(hwrite), .hwdata(hwdata), .hrdata(hrdata), .hready(hready),
        .hresp(hresp), .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
        .rd_valid(rd_valid), .rd_data(rd_data), .beats_done(beats_done),
        .err_flag(err_flag)
    );

    int n_chk = 0, n_fail = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // scoreboard items
    typedef struct {
        logic [AW-1:0] addr;
        logic          wr;
        logic          err;
        logic          last;
        logic [DW-1:0] wdata;
    } item_t;
    item_t sb_q[$];

    // environment knobs
    logic [AW-1:0] err_a0 = '1, err_a1 = '1;
    int   waits = 0;
    bit   gap_mode = 0;
    bit   cur_abort = 0;
    logic [2:0] cur_burst = 3'b001;
    int   acc_idx = 0;
    int   busy_seen = 0;
    int   wr_idx = 0, exp_widx = 0, gap_cnt = 0;
    bit   wr_hs = 0;

    // slave model state
    bit            dv = 0, dw = 0, es = 0;
    logic [AW-1:0] da = '0;
    int            wl = 0;
    bit            rd_exp_v = 0;
    logic [DW-1:0] rd_exp_d = '0;

    function automatic bit is_err(input logic [AW-1:0] a);
        return (a == err_a0) || (a == err_a1);
    endfunction

    task automatic complete(input logic [AW-1:0] a, input bit w, input bit e);
        item_t it;
        if (sb_q.size() == 0) begin
            chk(0, "R5", a, 32'hDEAD);
            return;
        end
        it = sb_q.pop_front();
        chk(it.addr == a, "R2", a, it.addr);
        chk(it.err == e, "R6", 32'(e), 32'(it.err));
        if (e) begin
            // second ERROR cycle: policy decides what is on the bus
            if (cur_abort || it.last) chk(htrans == 2'b00, "R5", 32'(htrans), 32'h0);
            else begin
                chk(htrans == 2'b11, "R6", 32'(htrans), 32'h3);
                chk(haddr == a + 4, "R6", haddr, a + 4);
            end
        end else if (w) begin
            chk(hwdata == it.wdata, "R8", hwdata, it.wdata);
        end else begin
            rd_exp_v = 1;
            rd_exp_d = a ^ 32'h5A5A_0000;
        end
    endtask

    always @(negedge clk) if (rst_n) begin
        // write source: retire the handshake seen last cycle
        if (wr_hs) begin
            wr_idx++;
            if (gap_mode) gap_cnt = 2;
        end
        wr_hs = 0;
        wr_valid = (gap_cnt == 0);
        if (gap_cnt > 0) gap_cnt--;
        wr_data = WBASE + DW'(wr_idx);
        rd_exp_v = 0;

        // slave response for this cycle
        if (dv) begin
            if (is_err(da)) begin
                if (!es) begin hready = 0; hresp = 1; es = 1; end
                else begin hready = 1; hresp = 1; es = 0; complete(da, dw, 1); end
            end else if (wl > 0) begin
                hready = 0; hresp = 0; wl--;
            end else begin
                hready = 1; hresp = 0;
                if (!dw) hrdata = da ^ 32'h5A5A_0000;
                complete(da, dw, 0);
            end
        end else begin
            hready = 1; hresp = 0;
        end
        if (hready) begin
            if (htrans[1]) begin
                if (acc_idx == 0) begin
                    chk(htrans == 2'b10, "R2", 32'(htrans), 32'h2);
                    chk(hburst == cur_burst, "R3", 32'(hburst), 32'(cur_burst));
                    chk(hsize == 3'd2, "R2", 32'(hsize), 32'h2);
                end else begin
                    chk(htrans == 2'b11, "R2", 32'(htrans), 32'h3);
                end
                acc_idx++;
                dv = 1; da = haddr; dw = hwrite; wl = waits;
            end else begin
                dv = 0;
            end
        end
        if (htrans == 2'b01) busy_seen++;

        #4;
        wr_hs = wr_valid && wr_ready;
        if (rd_exp_v || rd_valid)
            chk(rd_valid && rd_data == rd_exp_d, "R9", rd_data, rd_exp_d);
    end

    task automatic run_cmd(input logic [AW-1:0] base, input int beats, input bit w, input bit ab);
        int exp_ok = 0;
        bit exp_err = 0;
        for (int i = 0; i < beats; i++) begin
            item_t it;
            it.addr  = base + AW'(4 * i);
            it.wr    = w;
            it.err   = is_err(it.addr);
            it.last  = (i == beats - 1) || (it.err && ab);
            it.wdata = WBASE + DW'(exp_widx);
            if (w) exp_widx++;
            sb_q.push_back(it);
            if (it.err) exp_err = 1; else exp_ok++;
            if (it.err && ab) begin
                if (w && i < beats - 1) exp_widx++; // item taken for the cancelled beat
                break;
            end
        end
        cur_abort = ab;
        cur_burst = (beats == 4) ? 3'b011 : (beats == 8) ? 3'b101 : 3'b001;
        acc_idx = 0;
        @(negedge clk);
        cmd_valid = 1; cmd_addr = base; cmd_beats = CW'(beats);
        cmd_write = w; cmd_abort = ab;
        forever begin
            #4;
            if (cmd_ready) break;
            @(negedge clk);
        end
        @(negedge clk);
        cmd_valid = 0;
        #4 chk(!cmd_ready, "R1", 32'(cmd_ready), 32'h0);
        forever begin
            @(negedge clk);
            #4;
            if (cmd_ready) break;
        end
        chk(sb_q.size() == 0, "R5", sb_q.size(), 32'h0);
        chk(beats_done == CW'(exp_ok), "R10", 32'(beats_done), exp_ok);
        chk(err_flag == exp_err, "R10", 32'(err_flag), 32'(exp_err));
        sb_q.delete();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        #3;
        chk(cmd_ready == 1'b1, "R1", 32'(cmd_ready), 32'h1);
        chk(htrans == 2'b00, "R3", 32'(htrans), 32'h0);
        chk(beats_done == '0, "R10", 32'(beats_done), 32'h0);
        chk(err_flag == 1'b0, "R10", 32'(err_flag), 32'h0);

        // R2 R3 R9: plain INCR4 read
        run_cmd(32'h20, 4, 0, 0);
        // R4 R8: INCR8 write with wait states
        waits = 1;
        run_cmd(32'h100, 8, 1, 0);
        waits = 0;
        // R6: undefined-length read, one error, continue
        err_a0 = 32'h28;
        run_cmd(32'h20, 5, 0, 0);
        // R6: two errors in a row, continue
        err_a1 = 32'h2C;
        run_cmd(32'h20, 5, 0, 0);
        err_a1 = '1;
        // R5: abort INCR4 read at third beat
        run_cmd(32'h20, 4, 0, 1);
        // R5 R10: fresh command after a cancel clears the flag
        run_cmd(32'h40, 4, 0, 1);
        // R5 R8: abort on a write drops the taken item
        run_cmd(32'h20, 4, 1, 1);
        run_cmd(32'h200, 3, 1, 0);
        // R5: error on the last beat in abort mode
        err_a0 = 32'h2C;
        run_cmd(32'h20, 4, 0, 1);
        err_a0 = '1;
        // R8: late write data forces BUSY
        gap_mode = 1; busy_seen = 0;
        run_cmd(32'h300, 8, 1, 0);
        chk(busy_seen > 0, "R8", busy_seen, 32'h1);
        gap_mode = 0;
        // R2 R3: single-beat and 6-beat reads with waits
        waits = 2;
        run_cmd(32'h400, 1, 0, 0);
        run_cmd(32'h500, 6, 0, 1);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule